// File: doc/BRIEF.md
# Banked Bit-Toggle Execution Unit

This unit carries out one single-word instruction: it inverts a chosen bit of an 8-bit location in data memory and leaves the other seven bits alone. It takes a 16-bit instruction word and the current 4-bit bank register. It drives a read port and a write port toward a data memory that writes synchronously and reads asynchronously. A free-running four-phase sequencer splits each instruction cycle into decode, read, modify and write phases. Each instruction therefore takes exactly four clocks, and a new instruction is accepted at the start of every cycle.

The 12-bit effective address comes from one of two sources, selected by one instruction bit. The first is the bank register placed above the 8-bit file field. The second is a fixed access window made of the lowest 128 and the highest 128 addresses of the space. Any instruction word whose top nibble is not the toggle opcode is flagged as illegal and never writes memory.

Top module: `bit_toggle_unit`

## Requirements
- R1: An instruction is a toggle when bits 15:12 equal 4'b0111. Bits 11:9 select the bit number, bit 8 is the bank-mode flag, and bits 7:0 are the file field f.
- R2: The value written equals the value read with only the selected bit inverted. For example, 8'h75 with bit 4 becomes 8'h65.
- R3: When the bank-mode flag is 0, the bank register is ignored. f values 8'h00–8'h7F address 12'h000–12'h07F, and f values 8'h80–8'hFF address 12'hF80–12'hFFF.
- R4: When the bank-mode flag is 1, the address is {bank[3:0], f[7:0]}.
- R5: phase_o repeats 0,1,2,3 (Q1 decode, Q2 read, Q3 modify, Q4 write), one step per clock. One instruction completes per four-clock cycle.
- R6: rd_en_o is high only in Q2, and read data is captured at the end of Q2. wr_en_o is high only in Q4, for exactly one clock, at the address that was read.
- R7: For a non-toggle opcode, illegal_o is high in Q2, Q3 and Q4 of that cycle, and neither rd_en_o nor wr_en_o is asserted.
- R8: During and right after reset, phase_o is 0 and wr_en_o, rd_en_o and illegal_o are 0.
- R9: Consecutive toggles of the same location see each other's results, so toggling a bit twice restores the original value.
- R10: instr_i and bank_i are sampled only at the end of Q1. Changes to them in Q2–Q4 do not alter that cycle's address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word, sampled at end of Q1 |
| bank_i | input | 4 | Bank register value, sampled at end of Q1 |
| phase_o | output | 2 | Current phase, 0 = Q1 through 3 = Q4 |
| rd_en_o | output | 1 | Read request, Q2 only |
| rd_addr_o | output | 12 | Read address |
| rd_data_i | input | 8 | Read data, valid in the same clock as rd_addr_o |
| wr_en_o | output | 1 | Write strobe, Q4 only |
| wr_addr_o | output | 12 | Write address |
| wr_data_o | output | 8 | Write data |
| illegal_o | output | 1 | Non-toggle opcode seen in this cycle |

## Verification
The bench walks the access window across its split point, 8'h7F against 8'h80. A design that extends the wrong bit, or that lets the bank register leak in, writes into the wrong bank. It toggles all eight bit numbers of one location and checks the pattern. An off-by-one in bit selection would set the wrong bits or flip more than one bit.

The bench disturbs instr_i and bank_i after Q1 in every cycle. A design that does not hold the decoded fields would change its address mid-cycle. Illegal opcodes and back-to-back toggles of the same location expose a stray write, or data read before the previous write has landed.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int OPC_W = 4;

endpackage

// File: rtl/bt_decode.sv
module bt_decode #(
    parameter int INSTR_W = 16,
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int F_W     = 8,
    parameter logic [bt_pkg::OPC_W-1:0] OPCODE = 4'b0111
) (
    input  logic [INSTR_W-1:0]         instr_i,
    input  logic [BANK_W-1:0]          bank_i,
    output logic                       legal_o,
    output logic [$clog2(DATA_W)-1:0]  bit_o,
    output logic [BANK_W+F_W-1:0]      addr_o
);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int ACC_POS = F_W;
    localparam int BIT_LSB = F_W + 1;

    logic [F_W-1:0] file_f;
    logic           bank_mode;

    assign file_f    = instr_i[F_W-1:0];
    assign bank_mode = instr_i[ACC_POS];
    assign bit_o     = instr_i[BIT_LSB +: BIT_W];
    assign legal_o   = (instr_i[INSTR_W-1 -: bt_pkg::OPC_W] == OPCODE);

    always_comb begin
        if (bank_mode) begin
            addr_o = {bank_i, file_f};
        end else begin
            addr_o = {{BANK_W{file_f[F_W-1]}}, file_f};
        end
    end

endmodule

// File: rtl/bt_modify.sv
module bt_modify #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]          data_i,
    input  logic [$clog2(DATA_W)-1:0]  bit_i,
    output logic [DATA_W-1:0]          data_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign data_o[i] = (int'(bit_i) == i) ? ~data_i[i] : data_i[i];
    end

endmodule

// File: rtl/bit_toggle_unit.sv
module bit_toggle_unit #(
    parameter int INSTR_W = 16,
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int F_W     = 8,
    parameter logic [bt_pkg::OPC_W-1:0] OPCODE = 4'b0111
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [INSTR_W-1:0]           instr_i,
    input  logic [BANK_W-1:0]            bank_i,
    output logic [1:0]                   phase_o,
    output logic                         rd_en_o,
    output logic [BANK_W+F_W-1:0]        rd_addr_o,
    input  logic [DATA_W-1:0]            rd_data_i,
    output logic                         wr_en_o,
    output logic [BANK_W+F_W-1:0]        wr_addr_o,
    output logic [DATA_W-1:0]            wr_data_o,
    output logic                         illegal_o
);
    import bt_pkg::*;

    localparam int ADDR_W = BANK_W + F_W;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef struct packed {
        phase_e              phase;
        logic                legal;
        logic [BIT_W-1:0]    bitpos;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   rdata;
        logic [DATA_W-1:0]   wdata;
    } state_t;

    state_t s_d, s_q;

    logic              dec_legal;
    logic [BIT_W-1:0]  dec_bit;
    logic [ADDR_W-1:0] dec_addr;
    logic [DATA_W-1:0] mod_data;

    bt_decode #(
        .INSTR_W (INSTR_W),
        .DATA_W  (DATA_W),
        .BANK_W  (BANK_W),
        .F_W     (F_W),
        .OPCODE  (OPCODE)
    ) u_decode (
        .instr_i (instr_i),
        .bank_i  (bank_i),
        .legal_o (dec_legal),
        .bit_o   (dec_bit),
        .addr_o  (dec_addr)
    );

    bt_modify #(
        .DATA_W (DATA_W)
    ) u_modify (
        .data_i (s_q.rdata),
        .bit_i  (s_q.bitpos),
        .data_o (mod_data)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = phase_e'(s_q.phase + 2'd1);
        case (s_q.phase)
            PH_Q1: begin
                s_d.legal  = dec_legal;
                s_d.bitpos = dec_bit;
                s_d.addr   = dec_addr;
            end
            PH_Q2: s_d.rdata = rd_data_i;
            PH_Q3: s_d.wdata = mod_data;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_Q1, legal: 1'b0, bitpos: '0,
                     addr: '0, rdata: '0, wdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o   = s_q.phase;
    assign rd_en_o   = (s_q.phase == PH_Q2) && s_q.legal;
    assign rd_addr_o = s_q.addr;
    assign wr_en_o   = (s_q.phase == PH_Q4) && s_q.legal;
    assign wr_addr_o = s_q.addr;
    assign wr_data_o = s_q.wdata;
    assign illegal_o = !s_q.legal && (s_q.phase != PH_Q1);

    // R2: exactly one bit differs between captured read data and write data
    a_r2_single_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $countones(wr_data_o ^ s_q.rdata) == 1);

    // R6: a write follows a read of the same address two clocks earlier
    a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(rd_en_o, 2) && $past(rd_addr_o, 2) == wr_addr_o));

    // R6: the strobe lasts a single clock
    a_r6_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R7: an illegal cycle performs no memory access
    a_r7_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !rd_en_o));

    // R5: the write phase is always followed by decode
    a_r5_wrap_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |=> (phase_o == 2'd0));

    // R10: the address is frozen outside decode
    a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |=> $stable(rd_addr_o));

endmodule

// File: tb/sim_bit_toggle_unit.sv
module sim_bit_toggle_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0000;
    logic [3:0]  bank_i = 4'h0;
    logic [1:0]  phase_o;
    logic        rd_en_o;
    logic [11:0] rd_addr_o;
    logic [7:0]  rd_data_i;
    logic        wr_en_o;
    logic [11:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        illegal_o;

    logic [7:0] mem [4096];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign rd_data_i = mem[rd_addr_o];
    always @(posedge clk) if (wr_en_o) mem[wr_addr_o] <= wr_data_o;

    bit_toggle_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr_i),
        .bank_i    (bank_i),
        .phase_o   (phase_o),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .illegal_o (illegal_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] opc, input int b,
                                       input logic a, input logic [7:0] f);
        return {opc, 3'(b), a, f};
    endfunction

    // One full instruction cycle; inputs disturbed after Q1 (R10)
    task automatic exec(input logic [15:0] ins, input logic [3:0] bank,
                        input logic [11:0] addr, input logic legal, input string tag);
        logic [7:0] old, expw;
        while (phase_o != 2'd0) @(negedge clk);
        instr_i = ins;
        bank_i  = bank;
        old  = mem[addr];
        expw = old ^ (8'h01 << ins[11:9]);
        @(negedge clk);
        chk({tag, " R5 phase Q2"}, phase_o, 1);
        chk({tag, " R6 rd_en Q2"}, rd_en_o, legal);
        chk({tag, " R7 illegal Q2"}, illegal_o, !legal);
        if (legal) chk({tag, " rd_addr"}, rd_addr_o, addr);
        instr_i = ~ins;
        bank_i  = ~bank;
        @(negedge clk);
        chk({tag, " R5 phase Q3"}, phase_o, 2);
        chk({tag, " R6 no write Q3"}, wr_en_o, 0);
        @(negedge clk);
        chk({tag, " R5 phase Q4"}, phase_o, 3);
        chk({tag, " R6 wr_en Q4"}, wr_en_o, legal);
        chk({tag, " R7 illegal Q4"}, illegal_o, !legal);
        if (legal) begin
            chk({tag, " R10 wr_addr"}, wr_addr_o, addr);
            chk({tag, " R2 wr_data"}, wr_data_o, expw);
        end
        @(negedge clk);
        chk({tag, " R5 phase back to Q1"}, phase_o, 0);
        chk({tag, " R6 strobe ended"}, wr_en_o, 0);
        chk({tag, " memory"}, mem[addr], legal ? expw : old);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 phase in reset", phase_o, 0);
        chk("R8 wr_en in reset", wr_en_o, 0);
        chk("R8 rd_en in reset", rd_en_o, 0);
        chk("R8 illegal in reset", illegal_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 first phase after reset", phase_o, 1);
        chk("R8 no write after reset", wr_en_o, 0);
    endtask

    task automatic t_example();
        mem[12'h275] = 8'h75;
        exec(mk(4'b0111, 4, 1'b1, 8'h75), 4'h2, 12'h275, 1'b1, "R2 R1 example");
        chk("R2 example result", mem[12'h275], 8'h65);
    endtask

    task automatic t_access();
        mem[12'h07F] = 8'h00;
        mem[12'hF80] = 8'h00;
        mem[12'h010] = 8'hAA;
        mem[12'hFFF] = 8'h0F;
        exec(mk(4'b0111, 0, 1'b0, 8'h7F), 4'h5, 12'h07F, 1'b1, "R3 low top");
        exec(mk(4'b0111, 7, 1'b0, 8'h80), 4'h5, 12'hF80, 1'b1, "R3 high bottom");
        exec(mk(4'b0111, 1, 1'b0, 8'h10), 4'hC, 12'h010, 1'b1, "R3 low");
        exec(mk(4'b0111, 3, 1'b0, 8'hFF), 4'h0, 12'hFFF, 1'b1, "R3 high top");
        chk("R3 bank 5 untouched", mem[12'h57F], 8'h00);
    endtask

    task automatic t_banked();
        mem[12'hA33] = 8'hFF;
        mem[12'h080] = 8'h00;
        exec(mk(4'b0111, 5, 1'b1, 8'h33), 4'hA, 12'hA33, 1'b1, "R4 bank A");
        exec(mk(4'b0111, 2, 1'b1, 8'h80), 4'h0, 12'h080, 1'b1, "R4 bank 0 high f");
        chk("R4 bank A result", mem[12'hA33], 8'hDF);
        chk("R4 bank 0 result", mem[12'h080], 8'h04);
    endtask

    task automatic t_all_bits();
        mem[12'h3C0] = 8'h00;
        for (int b = 0; b < 8; b++) begin
            exec(mk(4'b0111, b, 1'b1, 8'hC0), 4'h3, 12'h3C0, 1'b1, "R1 bit sweep");
            chk("R1 bit sweep pattern", mem[12'h3C0], (1 << (b + 1)) - 1);
        end
    endtask

    task automatic t_back_to_back();
        mem[12'h123] = 8'h5A;
        exec(mk(4'b0111, 6, 1'b1, 8'h23), 4'h1, 12'h123, 1'b1, "R9 first");
        exec(mk(4'b0111, 6, 1'b1, 8'h23), 4'h1, 12'h123, 1'b1, "R9 second");
        chk("R9 restored", mem[12'h123], 8'h5A);
    endtask

    task automatic t_illegal();
        mem[12'h244] = 8'h3C;
        exec(mk(4'b0110, 2, 1'b1, 8'h44), 4'h2, 12'h244, 1'b0, "R7 opcode 6");
        exec(mk(4'b1111, 2, 1'b1, 8'h44), 4'h2, 12'h244, 1'b0, "R7 opcode F");
        chk("R7 memory unchanged", mem[12'h244], 8'h3C);
        exec(mk(4'b0111, 2, 1'b1, 8'h44), 4'h2, 12'h244, 1'b1, "R7 legal after illegal");
        chk("R7 recovers", mem[12'h244], 8'h38);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        t_example();
        t_access();
        t_banked();
        t_all_bits();
        t_back_to_back();
        t_illegal();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule